// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block sits on a processor's I/O bus and gives it two 8-bit parallel ports, A and B. The processor reaches four registers through an 8-bit bidirectional data bus. A chip-select line, two register-select lines and separate read and write strobes control each access. The block drives the data bus only while it is answering a read. At all other times the bus is left floating, so several interfaces can share it.

A control byte written by the processor sets the direction of each port at run time. In the usual assignment, port A carries data and port B carries commands. Port A has a device strobe that latches input data and sets a "new data" flag. Reading port A clears that flag. The status register combines the flag with seven device-side status lines.

Top module: `pport_if`

## Requirements
- R1: The data bus is high-impedance whenever chip select is low. It is also high-impedance when chip select is high but the read strobe is low.
- R2: With chip select high, register select 00 addresses port A, 01 port B, 10 control and 11 status.
- R3: With chip select high, read high and write low, the selected register drives the bus in the same cycle. With chip select high, write high and read low, the bus value is stored into the selected register at the clock edge.
- R4: The control register is 8 bits wide and every bit reads back. Bit 0 set to 1 makes port A an output, and bit 1 set to 1 makes port B an output. Each port's pin enables `pa_oe`/`pb_oe` are all ones in output mode and all zeros in input mode.
- R5: Port A in output mode drives `pa_out` with its written value, and a read returns that value. Port A in input mode latches `pa_in` on a clock edge where `pa_stb` is high, and a read returns the latched value. In output mode `pa_stb` is ignored. A write while port A is an input is kept and appears on `pa_out` once the port becomes an output.
- R6: Port B in output mode drives `pb_out` with its written value. In input mode a read returns `pb_in` as sampled at the previous clock edge.
- R7: Status bit 0 is set by a port A input latch and cleared by a port A read. If both happen in the same cycle, the flag ends up set. Status bits 7:1 show `dev_sts[6:0]`.
- R8: A write to the status address changes no register.
- R9: Read and write asserted together are a no-operation. The block does not drive the bus, stores nothing and does not clear the flag.
- R10: After reset the control register, both port output registers, the port A latch and the flag are zero, and both ports are inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| rs | input | 2 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| data_io | inout | 8 | Bidirectional processor data bus |
| pa_in | input | 8 | Port A pins, inbound |
| pa_stb | input | 1 | Device strobe that latches port A input |
| pa_out | output | 8 | Port A pins, outbound |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_in | input | 8 | Port B pins, inbound |
| pb_out | output | 8 | Port B pins, outbound |
| pb_oe | output | 8 | Port B pin drive enables |
| dev_sts | input | 7 | Device status lines shown in status bits 7:1 |

## Verification
A wrong control bit appears at once on the pin enables and on the control readback in the next access. Because of this, the bench sweeps all 256 control values and checks both. A bad decode or a stray bus drive shows up as a corrupted bus value during an access the block should ignore. The bench exposes it by driving zeros from its own side while non-zero registers sit behind the select. A flag fault shows on the status read one cycle after the strobe or read that should have moved it.

// File: rtl/pport_pkg.sv
// Shared definitions for the parallel port interface.
package pport_pkg;
    // Register select codes; the decode depends on this order.
    typedef enum logic [1:0] {
        SEL_PA  = 2'b00,
        SEL_PB  = 2'b01,
        SEL_CTL = 2'b10,
        SEL_STS = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/pport_decode.sv
// Access decoder: turns chip select, register select and strobes into
// one-hot write enables, a port A read event and the bus drive enable.
// Assumes strobes are synchronous to clk; rd and wr together is a no-op.
module pport_decode
    import pport_pkg::*;
#(
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            cs,
    input  logic [SELW-1:0] rs,
    input  logic            rd,
    input  logic            wr,
    output logic [NREG-1:0] wr_hit,
    output logic            rd_pa,
    output logic            bus_drv
);
    logic rd_act;
    logic wr_act;

    // Qualified strobes: exactly one of rd/wr, with chip selected.
    assign rd_act = cs && rd && !wr;
    assign wr_act = cs && wr && !rd;

    // One write enable per register address.
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign wr_hit[g] = wr_act && (rs == SELW'(g));
    end

    assign rd_pa   = rd_act && (rs == SEL_PA);
    assign bus_drv = rd_act;
endmodule

// File: rtl/pport_port.sv
// One parallel port: an output register, an inbound capture stage and
// direction-driven pin enables. LATCH_IN=1 captures on a device strobe
// (and reports it); LATCH_IN=0 samples the pins every cycle.
module pport_port #(
    parameter int W        = 8,
    parameter bit LATCH_IN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         dir_out,
    input  logic [W-1:0] pin_in,
    input  logic         stb,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val,
    output logic         new_in
);
    logic [W-1:0] out_q;
    logic [W-1:0] in_q;

    // Output register, loaded by processor writes regardless of direction.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_q <= '0;
        else if (wr_en) out_q <= wr_data;
    end

    if (LATCH_IN) begin : g_latch
        // Strobed capture, only while the port is an input.
        always_ff @(posedge clk) begin
            if (!rst_n)                in_q <= '0;
            else if (stb && !dir_out)  in_q <= pin_in;
        end
        assign new_in = stb && !dir_out;

        AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            dir_out |=> $stable(in_q)); // R5
    end else begin : g_sample
        // Free-running sample of the pins.
        always_ff @(posedge clk) begin
            if (!rst_n) in_q <= '0;
            else        in_q <= pin_in;
        end
        assign new_in = 1'b0;
    end

    assign pin_out = out_q;
    assign pin_oe  = {W{dir_out}};
    assign rd_val  = dir_out ? out_q : in_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(out_q)); // R3
endmodule

// File: rtl/pport_status.sv
// Status byte: bit 0 is the port A new-data flag, upper bits show device
// status lines. Set has priority over clear when both arrive together.
module pport_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_evt,
    input  logic         clr_evt,
    input  logic [W-2:0] dev_sts,
    output logic [W-1:0] sts_val
);
    logic flag_q;

    // New-data flag: set by a capture, cleared by a port A read.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_evt) flag_q <= 1'b0;
    end

    assign sts_val = {dev_sts, flag_q};

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q); // R7
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag_q); // R7
endmodule

// File: rtl/pport_if.sv
// Programmable parallel port interface. Four registers behind a shared
// tri-state data bus; the control byte sets each port's direction.
// Assumes bus strobes are synchronous to clk; reads are combinational.
module pport_if
    import pport_pkg::*;
#(
    parameter int DW   = 8,
    localparam int NREG = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic [SELW-1:0] rs,
    input  logic            rd,
    input  logic            wr,
    inout  wire  [DW-1:0]   data_io,
    input  logic [DW-1:0]   pa_in,
    input  logic            pa_stb,
    output logic [DW-1:0]   pa_out,
    output logic [DW-1:0]   pa_oe,
    input  logic [DW-1:0]   pb_in,
    output logic [DW-1:0]   pb_out,
    output logic [DW-1:0]   pb_oe,
    input  logic [DW-2:0]   dev_sts
);
    logic [NREG-1:0] wr_hit;
    logic            rd_pa;
    logic            bus_drv;
    logic [DW-1:0]   ctrl_q;
    logic [DW-1:0]   pa_rd;
    logic [DW-1:0]   pb_rd;
    logic [DW-1:0]   sts_rd;
    logic            pa_new;
    logic [DW-1:0]   rd_mux;

    pport_decode #(.NREG(NREG)) u_dec (
        .cs(cs), .rs(rs), .rd(rd), .wr(wr),
        .wr_hit(wr_hit), .rd_pa(rd_pa), .bus_drv(bus_drv)
    );

    // Control byte: bit 0 port A direction, bit 1 port B direction.
    always_ff @(posedge clk) begin
        if (!rst_n)               ctrl_q <= '0;
        else if (wr_hit[SEL_CTL]) ctrl_q <= data_io;
    end

    pport_port #(.W(DW), .LATCH_IN(1'b1)) u_pa (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_PA]), .wr_data(data_io),
        .dir_out(ctrl_q[0]), .pin_in(pa_in), .stb(pa_stb),
        .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(pa_rd), .new_in(pa_new)
    );

    logic pb_new_unused;
    pport_port #(.W(DW), .LATCH_IN(1'b0)) u_pb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[SEL_PB]), .wr_data(data_io),
        .dir_out(ctrl_q[1]), .pin_in(pb_in), .stb(1'b0),
        .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(pb_rd), .new_in(pb_new_unused)
    );

    pport_status #(.W(DW)) u_sts (
        .clk(clk), .rst_n(rst_n), .set_evt(pa_new), .clr_evt(rd_pa),
        .dev_sts(dev_sts), .sts_val(sts_rd)
    );

    // Read data select by register address.
    always_comb begin
        case (rs)
            SEL_PA:  rd_mux = pa_rd;
            SEL_PB:  rd_mux = pb_rd;
            SEL_CTL: rd_mux = ctrl_q;
            default: rd_mux = sts_rd;
        endcase
    end

    assign data_io = bus_drv ? rd_mux : {DW{1'bz}};

    AST_BUS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !bus_drv); // R1
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit[SEL_CTL] |=> $stable(ctrl_q)); // R4
    AST_STS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !rd && rs == SEL_STS) |=>
            ($stable(ctrl_q) && $stable(pa_out) && $stable(pb_out))); // R8
    AST_RW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && wr) |=>
            ($stable(ctrl_q) && $stable(pa_out) && $stable(pb_out))); // R9
    AST_RW_NODRV: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && wr) |-> !bus_drv); // R9
endmodule

// File: tb/pport_if_test.sv
`timescale 1ns/1ps
module pport_if_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] rs = 2'b00;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
    logic       pa_stb = 1'b0;
    logic [6:0] dev_sts = 7'h35;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic [7:0] tb_dat = 8'h00;
    logic       tb_drv = 1'b0;
    wire  [7:0] bus;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign bus = tb_drv ? tb_dat : 8'hzz;

    always #2.5 clk = ~clk;

    pport_if uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .rd(rd), .wr(wr),
        .data_io(bus), .pa_in(pa_in), .pa_stb(pa_stb), .pa_out(pa_out),
        .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .dev_sts(dev_sts)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rs = a; wr = 1'b1; tb_dat = v; tb_drv = 1'b1;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; tb_drv = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rs = a; rd = 1'b1;
        #1 v = bus;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic strobe_a(input logic [7:0] v);
        @(negedge clk);
        pa_in = v; pa_stb = 1'b1;
        @(negedge clk);
        pa_stb = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] sts_hi;
        sts_hi = {7'h35, 1'b0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 pa_oe", pa_oe, 8'h00);
        chk("R10 pb_oe", pb_oe, 8'h00);
        chk("R10 pa_out", pa_out, 8'h00);
        bus_rd(2'b10, v); chk("R10 ctrl", v, 8'h00);
        bus_rd(2'b11, v); chk("R10 status", v, sts_hi);
        bus_rd(2'b00, v); chk("R10 port A latch", v, 8'h00);

        // R4: full control byte sweep
        for (int c = 0; c < 256; c++) begin
            bus_wr(2'b10, 8'(c));
            bus_rd(2'b10, v);
            chk("R4 ctrl readback", v, 8'(c));
            chk("R4 pa_oe", pa_oe, {8{c[0]}});
            chk("R4 pb_oe", pb_oe, {8{c[1]}});
        end

        // R5 / R3: port A output patterns
        bus_wr(2'b10, 8'h01);
        for (int i = 0; i < 16; i++) begin
            bus_wr(2'b00, 8'((i * 17) ^ 8'h5A));
            chk("R5 pa_out", pa_out, 8'((i * 17) ^ 8'h5A));
            bus_rd(2'b00, v);
            chk("R3 port A read", v, 8'((i * 17) ^ 8'h5A));
        end

        // R5 / R7: port A input capture and flag
        bus_wr(2'b10, 8'h00);
        for (int i = 0; i < 8; i++) begin
            strobe_a(8'(8'hC3 + i * 29));
            pa_in = 8'hEE;
            bus_rd(2'b11, v); chk("R7 flag set", v, sts_hi | 8'h01);
            bus_rd(2'b00, v); chk("R5 latched read", v, 8'(8'hC3 + i * 29));
            bus_rd(2'b11, v); chk("R7 flag cleared", v, sts_hi);
        end
        // R5: write while input kept, shown on switch to output
        bus_wr(2'b00, 8'h9C);
        chk("R5 pa_oe input", pa_oe, 8'h00);
        bus_wr(2'b10, 8'h01);
        chk("R5 held write", pa_out, 8'h9C);
        // R5: strobe ignored in output mode
        strobe_a(8'h11);
        bus_rd(2'b11, v); chk("R5 strobe ignored flag", v, sts_hi);
        bus_wr(2'b10, 8'h00);
        bus_rd(2'b00, v); chk("R5 strobe ignored data", v, 8'(8'hC3 + 7 * 29));

        // R7: strobe and read in the same cycle, set wins
        @(negedge clk);
        pa_in = 8'h66; pa_stb = 1'b1; cs = 1'b1; rs = 2'b00; rd = 1'b1;
        @(negedge clk);
        pa_stb = 1'b0; cs = 1'b0; rd = 1'b0;
        bus_rd(2'b11, v); chk("R7 set wins", v, sts_hi | 8'h01);
        bus_rd(2'b00, v); chk("R7 data with set", v, 8'h66);

        // R6: port B input samples and output patterns
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); pb_in = 8'(i * 37 + 5);
            bus_rd(2'b01, v); chk("R6 pb input", v, 8'(i * 37 + 5));
        end
        bus_wr(2'b10, 8'h02);
        for (int i = 0; i < 8; i++) begin
            bus_wr(2'b01, 8'(8'hF0 ^ (i * 9)));
            chk("R6 pb_out", pb_out, 8'(8'hF0 ^ (i * 9)));
            chk("R6 pb_oe", pb_oe, 8'hFF);
            bus_rd(2'b01, v); chk("R6 pb read", v, 8'(8'hF0 ^ (i * 9)));
        end

        // R2: distinct content at each address
        bus_wr(2'b10, 8'hA3);
        bus_wr(2'b00, 8'h11);
        bus_wr(2'b01, 8'h22);
        bus_rd(2'b00, v); chk("R2 addr 00", v, 8'h11);
        bus_rd(2'b01, v); chk("R2 addr 01", v, 8'h22);
        bus_rd(2'b10, v); chk("R2 addr 10", v, 8'hA3);
        bus_rd(2'b11, v); chk("R2 addr 11", v, sts_hi);

        // R8: status write ignored
        bus_wr(2'b11, 8'hFF);
        bus_rd(2'b10, v); chk("R8 ctrl kept", v, 8'hA3);
        chk("R8 pa_out kept", pa_out, 8'h11);
        chk("R8 pb_out kept", pb_out, 8'h22);
        bus_rd(2'b11, v); chk("R8 status kept", v, sts_hi);

        // R1: no drive when deselected or idle (bench drives zeros)
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            cs = 1'b0; rd = 1'b1; rs = 2'(a); tb_dat = 8'h00; tb_drv = 1'b1;
            #1 chk("R1 deselected float", bus, 8'h00);
            cs = 1'b1; rd = 1'b0;
            #1 chk("R1 idle float", bus, 8'h00);
            @(negedge clk);
            cs = 1'b0; tb_drv = 1'b0;
        end
        rd = 1'b0;

        // R9: read and write together
        bus_wr(2'b10, 8'h00);
        strobe_a(8'h5D);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            cs = 1'b1; rs = 2'(a); rd = 1'b1; wr = 1'b1; tb_dat = 8'h00; tb_drv = 1'b1;
            #1 chk("R9 no drive", bus, 8'h00);
            @(negedge clk);
            cs = 1'b0; rd = 1'b0; wr = 1'b0; tb_drv = 1'b0;
        end
        bus_rd(2'b11, v); chk("R9 flag kept", v, sts_hi | 8'h01);
        chk("R9 pa_out kept", pa_out, 8'h11);
        chk("R9 pb_out kept", pb_out, 8'h22);
        bus_rd(2'b10, v); chk("R9 ctrl kept", v, 8'h00);
        dev_sts = 7'h4B;
        bus_rd(2'b11, v); chk("R7 upper status", v, {7'h4B, 1'b1});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule